// File: doc/BRIEF.md
# Configuration-Space Target Responder

This block is the target side of a parallel, multiplexed address/data bus. It answers configuration read and configuration write cycles for a single-function device. It watches the bus for address phases and gives every command nibble a class code. It claims only the configuration cycles that are qualified by the device-select input, and it completes each claimed cycle with fixed timing. DEVSEL is driven at medium decode time and TRDY on the fourth data-phase clock. Each cycle carries exactly one data phase.

Behind the bus side is a 64-dword configuration array. Writes to it honour the byte enables. Two conditions end a cycle with STOP:

- The initiator tries to burst. The responder then disconnects after the first data phase.
- A post-reset serial preload is still running, shown by a busy input. The cycle then ends with a retry and no data moves.

Bus control pins are active-low and the AD bus is split into an input, an output and an output enable.

Top module: `cfg_target`

## Requirements
- R1: A cycle is claimed only if, at the address-phase edge, `idsel` is 1, `ad_in[1:0]` is 00 and `cbe_n` is 1010 (config read) or 1011 (config write). Any other address phase leaves `devsel_n`, `trdy_n` and `stop_n` high.
- R2: The dword index is `ad_in[7:2]`. Bits `ad_in[31:8]` have no effect on which dword is accessed.
- R3: On a write, byte lane k (`ad_in[8k+7:8k]`) is stored only when `cbe_n[k]` is 0 in the data phase. Other lanes keep their contents. 8-, 16- and 32-bit writes all work.
- R4: Call the rising edge that samples the address phase edge N. `devsel_n` goes low after edge N+1 and is still high between edges N and N+1.
- R5: `trdy_n` goes low after edge N+3. On a read, `ad_oe` rises after edge N+2 and `ad_out` carries the dword while `trdy_n` is low. On a write, `ad_oe` stays low.
- R6: The data phase completes at the first edge where `trdy_n` and `irdy_n` are both low. If `frame_n` is high at that edge, `devsel_n`, `trdy_n` and `stop_n` all go high together after it and `ad_oe` goes low.
- R7: If `frame_n` is still low at edge N+3, `stop_n` goes low together with `trdy_n`. If `frame_n` is low at the completing edge, `trdy_n` rises, `stop_n` and `devsel_n` stay low until `frame_n` is sampled high, and only the first data phase is written.
- R8: If `preload_busy` is 1 at edge N+3, `stop_n` goes low while `trdy_n` stays high. No write takes place. The signals are released after the first edge that samples `frame_n` high.
- R9: Bit 23 of dword 1 (the fast back-to-back capable status flag) always reads 1, even after it is written with 0.
- R10: An address phase is recognised whenever `frame_n` is sampled low after an edge that sampled it high. This includes the edge right after another target's last data phase, with no idle cycle between.
- R11: One cycle after every address-phase edge, `addr_strobe` is 1 for a single cycle and `cmd_cls` gives the class. The codes are: 0 none (0000, 0001, 0100, 0101, 1000, 1001, 1101), 1 I/O read (0010), 2 I/O write (0011), 3 memory read (0110, 1100, 1110), 4 memory write (0111, 1111), 5 config read (1010), 6 config write (1011).
- R12: After synchronous reset, `devsel_n`, `trdy_n` and `stop_n` are high, `ad_oe` and `addr_strobe` are 0, and every configuration dword reads 0 apart from the R9 flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| frame_n | input | 1 | Cycle framing from the initiator, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration device select, active high |
| cbe_n | input | 4 | Command in the address phase, byte enables (active low) in the data phase |
| ad_in | input | 32 | Address/data bus as seen by the target |
| preload_busy | input | 1 | Post-reset configuration preload still running |
| ad_out | output | 32 | Read data driven toward the bus |
| ad_oe | output | 1 | Output enable for `ad_out` |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop request (disconnect or retry), active low |
| addr_strobe | output | 1 | One-cycle pulse after each recognised address phase |
| cmd_cls | output | 3 | Class code of the last address phase (R11 encoding) |

## Verification
Suppose the phase sequencer ends up in the wrong state. A wrong state after a claim shows at the next edge as an early or late falling `devsel_n` or `trdy_n`, because every step of the sequence is one edge apart and each timed check samples a single cycle. A missed or duplicated address detection shows as a wrong `addr_strobe` or `cmd_cls` one cycle after the address edge. A wrong latched index or a bad byte merge shows on the read that follows, since every write is read back through the bus. A stuck retry or disconnect state shows as `stop_n` or `devsel_n` that is not released after `frame_n` is sampled high.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

    localparam int STATUS_DWORD = 1;
    localparam int FB2B_BIT     = 23;

    typedef enum logic [2:0] {
        CLS_NONE   = 3'd0,
        CLS_IO_RD  = 3'd1,
        CLS_IO_WR  = 3'd2,
        CLS_MEM_RD = 3'd3,
        CLS_MEM_WR = 3'd4,
        CLS_CFG_RD = 3'd5,
        CLS_CFG_WR = 3'd6
    } cmd_cls_e;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_DEC1,
        PH_DEC2,
        PH_WAIT,
        PH_XFER,
        PH_HOLD
    } phase_e;

    typedef struct packed {
        logic     hit;
        logic     claim;
        cmd_cls_e cls;
    } addr_info_t;

    function automatic cmd_cls_e classify(input logic [3:0] cmd);
        cmd_cls_e c;
        case (cmd)
            4'b0010: c = CLS_IO_RD;
            4'b0011: c = CLS_IO_WR;
            4'b0110: c = CLS_MEM_RD;
            4'b1100: c = CLS_MEM_RD;
            4'b1110: c = CLS_MEM_RD;
            4'b0111: c = CLS_MEM_WR;
            4'b1111: c = CLS_MEM_WR;
            4'b1010: c = CLS_CFG_RD;
            4'b1011: c = CLS_CFG_WR;
            default: c = CLS_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/cfgt_addr_decode.sv
module cfgt_addr_decode
    import cfgt_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_n,
    input  logic             idsel,
    input  logic [3:0]       cbe_n,
    input  logic [DW-1:0]    ad_in,
    output addr_info_t       info,
    output logic [IDX_W-1:0] idx,
    output logic             addr_strobe,
    output cmd_cls_e         cmd_cls
);

    logic     frame_q_n;
    cmd_cls_e cls_now;
    logic     ad_unused;

    assign ad_unused = ^ad_in[DW-1:IDX_W+2];

    always_ff @(posedge clk) begin
        if (rst) frame_q_n <= 1'b1;
        else     frame_q_n <= frame_n;
    end

    assign cls_now    = classify(cbe_n);
    assign info.hit   = !frame_n && frame_q_n;
    assign info.cls   = cls_now;
    assign info.claim = info.hit && idsel && (ad_in[1:0] == 2'b00) &&
                        ((cls_now == CLS_CFG_RD) || (cls_now == CLS_CFG_WR));
    assign idx        = ad_in[IDX_W+1:2];

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_strobe <= 1'b0;
            cmd_cls     <= CLS_NONE;
        end else begin
            addr_strobe <= info.hit;
            if (info.hit) cmd_cls <= cls_now;
        end
    end

endmodule

// File: rtl/cfgt_phase_fsm.sv
module cfgt_phase_fsm
    import cfgt_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int DW    = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  addr_info_t       info,
    input  logic [IDX_W-1:0] addr_idx,
    input  logic             frame_n,
    input  logic             irdy_n,
    input  logic             preload_busy,
    input  logic [DW-1:0]    rd_data,
    output logic [IDX_W-1:0] acc_idx,
    output logic             wr_en,
    output logic [DW-1:0]    ad_out,
    output logic             ad_oe,
    output logic             devsel_n,
    output logic             trdy_n,
    output logic             stop_n
);

    phase_e st;
    logic   is_wr;

    assign wr_en = (st == PH_XFER) && !irdy_n && is_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= PH_IDLE;
            is_wr    <= 1'b0;
            acc_idx  <= '0;
            ad_out   <= '0;
            ad_oe    <= 1'b0;
            devsel_n <= 1'b1;
            trdy_n   <= 1'b1;
            stop_n   <= 1'b1;
        end else begin
            case (st)
                PH_IDLE: begin
                    if (info.claim) begin
                        st      <= PH_DEC1;
                        is_wr   <= (info.cls == CLS_CFG_WR);
                        acc_idx <= addr_idx;
                    end
                end
                PH_DEC1: begin
                    st       <= PH_DEC2;
                    devsel_n <= 1'b0;
                end
                PH_DEC2: begin
                    st    <= PH_WAIT;
                    ad_oe <= !is_wr;
                end
                PH_WAIT: begin
                    if (preload_busy) begin
                        st     <= PH_HOLD;
                        stop_n <= 1'b0;
                        ad_oe  <= 1'b0;
                    end else begin
                        st     <= PH_XFER;
                        trdy_n <= 1'b0;
                        stop_n <= frame_n;
                        ad_out <= is_wr ? '0 : rd_data;
                    end
                end
                PH_XFER: begin
                    if (!irdy_n) begin
                        trdy_n <= 1'b1;
                        ad_oe  <= 1'b0;
                        ad_out <= '0;
                        if (!frame_n) begin
                            st     <= PH_HOLD;
                            stop_n <= 1'b0;
                        end else begin
                            st       <= PH_IDLE;
                            devsel_n <= 1'b1;
                            stop_n   <= 1'b1;
                        end
                    end
                end
                PH_HOLD: begin
                    if (frame_n) begin
                        st       <= PH_IDLE;
                        devsel_n <= 1'b1;
                        stop_n   <= 1'b1;
                    end
                end
                default: st <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/cfgt_regfile.sv
module cfgt_regfile #(
    parameter int IDX_W    = 6,
    parameter int DW       = 32,
    parameter int STAT_IDX = 1,
    parameter int STAT_BIT = 23
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wr_data,
    input  logic [DW/8-1:0]  wr_ben_n,
    output logic [DW-1:0]    rd_data
);

    localparam int DEPTH = 1 << IDX_W;
    localparam int NB    = DW / 8;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] cur;
    logic [DW-1:0] merged;

    assign cur = mem[idx];

    for (genvar b = 0; b < NB; b++) begin : g_lane
        assign merged[b*8 +: 8] = wr_ben_n[b] ? cur[b*8 +: 8] : wr_data[b*8 +: 8];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[idx] <= merged;
        end
    end

    always_comb begin
        rd_data = cur;
        if (idx == IDX_W'(STAT_IDX)) rd_data[STAT_BIT] = 1'b1;
    end

endmodule

// File: rtl/cfg_target.sv
module cfg_target
    import cfgt_pkg::*;
#(
    parameter int IDX_W = 6,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          frame_n,
    input  logic          irdy_n,
    input  logic          idsel,
    input  logic [3:0]    cbe_n,
    input  logic [DW-1:0] ad_in,
    input  logic          preload_busy,
    output logic [DW-1:0] ad_out,
    output logic          ad_oe,
    output logic          devsel_n,
    output logic          trdy_n,
    output logic          stop_n,
    output logic          addr_strobe,
    output logic [2:0]    cmd_cls
);

    addr_info_t       info;
    logic [IDX_W-1:0] addr_idx;
    logic [IDX_W-1:0] acc_idx;
    logic             wr_en;
    logic [DW-1:0]    rd_data;
    cmd_cls_e         cls_q;

    assign cmd_cls = cls_q;

    cfgt_addr_decode #(.IDX_W(IDX_W), .DW(DW)) u_dec (
        .clk(clk), .rst(rst), .frame_n(frame_n), .idsel(idsel),
        .cbe_n(cbe_n), .ad_in(ad_in), .info(info), .idx(addr_idx),
        .addr_strobe(addr_strobe), .cmd_cls(cls_q)
    );

    cfgt_phase_fsm #(.IDX_W(IDX_W), .DW(DW)) u_fsm (
        .clk(clk), .rst(rst), .info(info), .addr_idx(addr_idx),
        .frame_n(frame_n), .irdy_n(irdy_n), .preload_busy(preload_busy),
        .rd_data(rd_data), .acc_idx(acc_idx), .wr_en(wr_en),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n),
        .trdy_n(trdy_n), .stop_n(stop_n)
    );

    cfgt_regfile #(.IDX_W(IDX_W), .DW(DW), .STAT_IDX(STATUS_DWORD), .STAT_BIT(FB2B_BIT)) u_rf (
        .clk(clk), .rst(rst), .wr_en(wr_en), .idx(acc_idx),
        .wr_data(ad_in), .wr_ben_n(cbe_n), .rd_data(rd_data)
    );

endmodule

// File: rtl/cfgt_checker.sv
module cfgt_checker (
    input logic clk,
    input logic rst,
    input logic frame_n,
    input logic idsel,
    input logic devsel_n,
    input logic trdy_n,
    input logic stop_n,
    input logic ad_oe,
    input logic addr_strobe
);

    AST_TRDY_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        !trdy_n |-> !devsel_n); // R5

    AST_STOP_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (rst)
        !stop_n |-> !devsel_n); // R7

    AST_MEDIUM_DECODE: assert property (@(posedge clk) disable iff (rst)
        $fell(devsel_n) |-> (!$past(frame_n, 2) && $past(frame_n, 3) && $past(idsel, 2))); // R4

    AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
        $rose(devsel_n) |-> (trdy_n && stop_n)); // R6

    AST_NO_DRIVE_UNCLAIMED: assert property (@(posedge clk) disable iff (rst)
        devsel_n |-> !ad_oe); // R5

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> !addr_strobe); // R11

endmodule

bind cfg_target cfgt_checker u_chk (
    .clk(clk), .rst(rst), .frame_n(frame_n), .idsel(idsel),
    .devsel_n(devsel_n), .trdy_n(trdy_n), .stop_n(stop_n),
    .ad_oe(ad_oe), .addr_strobe(addr_strobe)
);

// File: tb/tb_cfg_target.sv
module tb_cfg_target;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        frame_n, irdy_n, idsel, preload_busy;
    logic [3:0]  cbe_n;
    logic [31:0] ad_in;
    logic [31:0] ad_out;
    logic        ad_oe, devsel_n, trdy_n, stop_n, addr_strobe;
    logic [2:0]  cmd_cls;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // cmd nibble, expected class code (R11)
    localparam logic [6:0] CLS_TAB [16] = '{
        {4'b0000, 3'd0}, {4'b0001, 3'd0}, {4'b0010, 3'd1}, {4'b0011, 3'd2},
        {4'b0100, 3'd0}, {4'b0101, 3'd0}, {4'b0110, 3'd3}, {4'b0111, 3'd4},
        {4'b1000, 3'd0}, {4'b1001, 3'd0}, {4'b1010, 3'd5}, {4'b1011, 3'd6},
        {4'b1100, 3'd3}, {4'b1101, 3'd0}, {4'b1110, 3'd3}, {4'b1111, 3'd4}
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_target dut (
        .clk(clk), .rst(rst), .frame_n(frame_n), .irdy_n(irdy_n), .idsel(idsel),
        .cbe_n(cbe_n), .ad_in(ad_in), .preload_busy(preload_busy),
        .ad_out(ad_out), .ad_oe(ad_oe), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .addr_strobe(addr_strobe), .cmd_cls(cmd_cls)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Starts and ends at a negedge. Timing checks for R4, R5, R6, R7.
    task automatic cfg_cycle(input bit wr, input logic [31:0] addr, input logic [3:0] ben_n,
                             input logic [31:0] wd, input bit burst, output logic [31:0] rd);
        frame_n = 1'b0; irdy_n = 1'b1; idsel = 1'b1; ad_in = addr;
        cbe_n = wr ? 4'b1011 : 4'b1010;
        @(posedge clk); @(negedge clk);                 // after edge N
        idsel = 1'b0; ad_in = wd; cbe_n = ben_n; irdy_n = 1'b0; frame_n = burst ? 1'b0 : 1'b1;
        chk(devsel_n === 1'b1, "R4 devsel early", 32'(devsel_n), 32'h1);
        @(posedge clk); @(negedge clk);                 // after N+1
        chk(devsel_n === 1'b0, "R4 devsel at N+1", 32'(devsel_n), 32'h0);
        chk(trdy_n === 1'b1, "R5 trdy early", 32'(trdy_n), 32'h1);
        @(posedge clk); @(negedge clk);                 // after N+2
        chk(ad_oe === !wr, "R5 ad_oe at N+2", 32'(ad_oe), 32'(!wr));
        @(posedge clk); @(negedge clk);                 // after N+3
        chk(trdy_n === 1'b0, "R5 trdy at N+3", 32'(trdy_n), 32'h0);
        chk(stop_n === !burst, "R7 stop with trdy", 32'(stop_n), 32'(!burst));
        rd = ad_out;
        @(posedge clk); @(negedge clk);                 // after N+4, completion
        if (!burst) begin
            chk({devsel_n, trdy_n, stop_n, ad_oe} === 4'b1110, "R6 release",
                32'({devsel_n, trdy_n, stop_n, ad_oe}), 32'hE);
        end else begin
            chk({devsel_n, trdy_n, stop_n} === 3'b010, "R7 disconnect hold",
                32'({devsel_n, trdy_n, stop_n}), 32'h2);
            frame_n = 1'b1;
            @(posedge clk); @(negedge clk);
            chk({devsel_n, trdy_n, stop_n} === 3'b111, "R7 release after frame",
                32'({devsel_n, trdy_n, stop_n}), 32'h7);
        end
        irdy_n = 1'b1; cbe_n = 4'b0000; ad_in = '0;
    endtask

    task automatic rd_check(input logic [31:0] addr, input logic [31:0] exp, input string req);
        logic [31:0] r;
        cfg_cycle(1'b0, addr, 4'b0000, 32'h0, 1'b0, r);
        chk(r === exp, req, r, exp);
    endtask

    task automatic wr_do(input logic [31:0] addr, input logic [3:0] ben_n, input logic [31:0] wd);
        logic [31:0] r;
        cfg_cycle(1'b1, addr, ben_n, wd, 1'b0, r);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        rst = 1'b1; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
        cbe_n = 4'b0000; ad_in = '0; preload_busy = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R12 reset state
        chk({devsel_n, trdy_n, stop_n, ad_oe, addr_strobe} === 5'b11100, "R12 reset outputs",
            32'({devsel_n, trdy_n, stop_n, ad_oe, addr_strobe}), 32'h1C);

        // R11 / R1 class table, idsel low so nothing is claimed
        for (int i = 0; i < 16; i++) begin
            frame_n = 1'b0; idsel = 1'b0; cbe_n = CLS_TAB[i][6:3]; ad_in = '0;
            @(posedge clk); @(negedge clk);
            chk(addr_strobe === 1'b1, "R11 strobe", 32'(addr_strobe), 32'h1);
            chk(cmd_cls === CLS_TAB[i][2:0], "R11 class", 32'(cmd_cls), 32'(CLS_TAB[i][2:0]));
            frame_n = 1'b1; irdy_n = 1'b0;
            @(posedge clk); @(negedge clk);
            chk(addr_strobe === 1'b0, "R11 strobe single", 32'(addr_strobe), 32'h0);
            irdy_n = 1'b1;
            repeat (3) begin
                @(posedge clk); @(negedge clk);
                chk(devsel_n === 1'b1, "R1 no claim without idsel", 32'(devsel_n), 32'h1);
            end
        end

        rd_check(32'h0000_0014, 32'h0, "R12 reset contents");

        // R3 full / byte / halfword writes
        wr_do(32'h0000_0014, 4'b0000, 32'hA5A5_1234);
        rd_check(32'h0000_0014, 32'hA5A5_1234, "R3 dword write");
        wr_do(32'h0000_0014, 4'b1110, 32'hFFFF_FF77);
        rd_check(32'h0000_0014, 32'hA5A5_1277, "R3 byte write");
        wr_do(32'h0000_0014, 4'b0011, 32'hBEEF_0000);
        rd_check(32'h0000_0014, 32'hBEEF_1277, "R3 halfword write");

        // R2 upper address bits ignored
        wr_do(32'hFFFF_FFFC, 4'b0000, 32'h0BAD_F00D);
        rd_check(32'h0000_00FC, 32'h0BAD_F00D, "R2 high bits ignored on write");
        rd_check(32'h1234_5714, 32'hBEEF_1277, "R2 high bits ignored on read");

        // R9 fast back-to-back flag
        wr_do(32'h0000_0004, 4'b0000, 32'h0000_0000);
        rd_check(32'h0000_0004, 32'h0080_0000, "R9 status flag");

        // R7 burst attempt: one write only
        cfg_cycle(1'b1, 32'h0000_001C, 4'b0000, 32'h1111_2222, 1'b1, r);
        rd_check(32'h0000_001C, 32'h1111_2222, "R7 single data phase");

        // R8 retry while preload busy
        preload_busy = 1'b1;
        frame_n = 1'b0; idsel = 1'b1; ad_in = 32'h0000_0014; cbe_n = 4'b1011;
        @(posedge clk); @(negedge clk);
        idsel = 1'b0; ad_in = 32'h0; cbe_n = 4'b0000; irdy_n = 1'b0; frame_n = 1'b1;
        repeat (3) begin @(posedge clk); @(negedge clk); end
        chk({devsel_n, trdy_n, stop_n} === 3'b010, "R8 retry signalling",
            32'({devsel_n, trdy_n, stop_n}), 32'h2);
        @(posedge clk); @(negedge clk);
        chk({devsel_n, trdy_n, stop_n} === 3'b111, "R8 retry release",
            32'({devsel_n, trdy_n, stop_n}), 32'h7);
        irdy_n = 1'b1; preload_busy = 1'b0;
        rd_check(32'h0000_0014, 32'hBEEF_1277, "R8 no write on retry");

        // R1 misaligned address bits not claimed
        frame_n = 1'b0; idsel = 1'b1; ad_in = 32'h0000_0015; cbe_n = 4'b1010;
        @(posedge clk); @(negedge clk);
        frame_n = 1'b1; idsel = 1'b0; irdy_n = 1'b0;
        repeat (4) begin
            @(posedge clk); @(negedge clk);
            chk({devsel_n, trdy_n, stop_n} === 3'b111, "R1 ad[1:0] nonzero",
                32'({devsel_n, trdy_n, stop_n}), 32'h7);
        end
        irdy_n = 1'b1;

        // R10 back-to-back after another target's last data phase
        frame_n = 1'b0; idsel = 1'b0; cbe_n = 4'b0111; ad_in = 32'h8000_0000;
        @(posedge clk); @(negedge clk);
        frame_n = 1'b1; irdy_n = 1'b0; cbe_n = 4'b0000;
        @(posedge clk); @(negedge clk);
        rd_check(32'h0000_001C, 32'h1111_2222, "R10 back-to-back claim");

        // R12 reset clears contents
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        rd_check(32'h0000_001C, 32'h0, "R12 contents after reset");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule